// File: doc/BRIEF.md
# Stack-and-PC priority fetch picker for a shared-front-end thread group

A group of hardware threads shares one instruction fetch unit. In every cycle this block decides which program counter the fetch unit serves. Each thread presents three things: an active flag, its stack pointer and its program counter. Among the active threads, the block picks the one whose combined key is smallest. The key places the stack pointer in the upper part and the program counter in the lower part. Because the stack grows toward lower addresses, a lower stack pointer means a deeper call level. The thread in the innermost function therefore runs first, and threads still in a caller wait for it to return. Once they wait, they tend to meet again at the same instruction.

Every active thread whose program counter equals the chosen one receives the fetched instruction in the same cycle. A single fetch can therefore serve many threads. The block registers its pick with one cycle of latency. It also keeps two 64-bit running totals: the number of cycles with a valid pick and the number of thread-services. Dividing the second total by the first gives the average number of threads served per fetch. A synchronous clear input restarts both totals.

Top module: `thread_fetch_picker`

## Requirements
- R1: When at least one thread is active, `win_idx_o` names the active thread with the smallest unsigned key {sp, pc}, with sp in the upper bits, and `win_pc_o` is that thread's pc.
- R2: A thread with a lower sp wins against a thread with a higher sp, whatever their pc values are.
- R3: When the sp values are equal, the thread with the smaller pc wins.
- R4: When both sp and pc are equal, the thread with the lower index wins.
- R5: Bit j of `served_mask_o` is 1 exactly when thread j is active and its pc equals the winning pc. The thread's sp does not matter for this test.
- R6: An inactive thread never wins and never appears in the served mask, even when its key is the smallest or its pc matches the winning pc.
- R7: When no thread is active, `pick_vld_o` is 0 and `served_mask_o`, `win_idx_o` and `win_pc_o` are all zero.
- R8: The outputs show the inputs sampled at the previous rising clock edge, which is one cycle of latency.
- R9: `pick_cnt_o` increases by 1 at each edge that registers a valid pick. `served_cnt_o` increases by the number of 1 bits in the mask registered at that same edge. Both counters are 64 bits wide.
- R10: When `clr_stats_i` is 1 at an edge, both counters become 0 at that edge, and that cycle's increment is dropped.
- R11: While `rst_n` is 0, all outputs and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_stats_i | input | 1 | Synchronous clear of both counters |
| act_i | input | N_THR | Per-thread active flags, bit j belongs to thread j |
| sp_i | input | N_THR*SP_W | Stack pointers; thread j uses bits [j*SP_W +: SP_W] |
| pc_i | input | N_THR*PC_W | Program counters; thread j uses bits [j*PC_W +: PC_W] |
| pick_vld_o | output | 1 | A pick was made |
| win_idx_o | output | $clog2(N_THR) | Index of the winning thread |
| win_pc_o | output | PC_W | Program counter to fetch |
| served_mask_o | output | N_THR | Threads that receive the fetched instruction |
| pick_cnt_o | output | 64 | Number of cycles with a valid pick |
| served_cnt_o | output | 64 | Total threads served |

## Verification
The bench goes after the cases where a single-field comparison would pick the wrong thread, listed here with the failure each one exposes:

- **Lower stack pointer with a higher program counter.** A picker that orders by program counter alone would choose the caller thread instead of the inner one.
- **Equal stack pointers.** A picker with an inverted tie-break would serve the larger program counter.
- **Fully equal keys.** A picker with the wrong tie-break direction would report a higher thread index.
- **Inactive thread with the smallest key or a matching program counter.** A picker that ignores the active flag would either let that thread win or add it to the mask.
- **Matching program counter under a different stack pointer.** A picker that masks on the whole key would leave that thread out.

The counters are checked across a clear that arrives in a cycle with a valid pick, where a design that gives the increment priority would keep a nonzero total. A long mixed phase uses few distinct key values so that ties happen often, and the bench compares every output against its own model on every cycle.

// File: rtl/tfp_pkg.sv
package tfp_pkg;
  localparam int unsigned DEF_THREADS = 16;
  localparam int unsigned DEF_SP_W    = 16;
  localparam int unsigned DEF_PC_W    = 16;
  localparam int unsigned STAT_W      = 64;
  typedef logic [STAT_W-1:0] stat_t;

  // lower half wins when it is valid and its key is not larger (index tie-break)
  function automatic logic lo_takes(input logic lo_v, input logic hi_v,
                                    input logic [63:0] lo_key, input logic [63:0] hi_key);
    return lo_v && (!hi_v || (lo_key <= hi_key));
  endfunction
endpackage

// File: rtl/tfp_pick_node.sv
module tfp_pick_node #(
  parameter int unsigned KEY_W = 32,
  parameter int unsigned IDX_W = 4
) (
  input  logic             lo_v,
  input  logic [KEY_W-1:0] lo_key,
  input  logic [IDX_W-1:0] lo_idx,
  input  logic             hi_v,
  input  logic [KEY_W-1:0] hi_key,
  input  logic [IDX_W-1:0] hi_idx,
  output logic             out_v,
  output logic [KEY_W-1:0] out_key,
  output logic [IDX_W-1:0] out_idx
);
  logic take_lo;
  assign take_lo = tfp_pkg::lo_takes(lo_v, hi_v, 64'(lo_key), 64'(hi_key));
  assign out_v   = lo_v | hi_v;
  assign out_key = take_lo ? lo_key : hi_key;
  assign out_idx = take_lo ? lo_idx : hi_idx;
endmodule

// File: rtl/tfp_pick_tree.sv
module tfp_pick_tree #(
  parameter int unsigned N     = 16,
  parameter int unsigned KEY_W = 32,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]       act,
  input  logic [N*KEY_W-1:0] keys,
  output logic               win_v,
  output logic [KEY_W-1:0]   win_key,
  output logic [IDX_W-1:0]   win_idx
);
  localparam int unsigned LEAVES = 1 << IDX_W;
  localparam int unsigned NODES  = 2 * LEAVES - 1;

  logic             nv [NODES];
  logic [KEY_W-1:0] nk [NODES];
  logic [IDX_W-1:0] ni [NODES];

  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    if (j < N) begin : g_real
      assign nv[LEAVES-1+j] = act[j];
      assign nk[LEAVES-1+j] = keys[j*KEY_W +: KEY_W];
    end else begin : g_pad
      assign nv[LEAVES-1+j] = 1'b0;
      assign nk[LEAVES-1+j] = '0;
    end
    assign ni[LEAVES-1+j] = IDX_W'(j);
  end

  // heap order: left child covers the lower thread indices
  for (genvar i = 0; i < LEAVES - 1; i++) begin : g_node
    tfp_pick_node #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_node (
      .lo_v  (nv[2*i+1]), .lo_key(nk[2*i+1]), .lo_idx(ni[2*i+1]),
      .hi_v  (nv[2*i+2]), .hi_key(nk[2*i+2]), .hi_idx(ni[2*i+2]),
      .out_v (nv[i]),     .out_key(nk[i]),    .out_idx(ni[i])
    );
  end

  assign win_v   = nv[0];
  assign win_key = nk[0];
  assign win_idx = ni[0];
endmodule

// File: rtl/tfp_serve_mask.sv
module tfp_serve_mask #(
  parameter int unsigned N    = 16,
  parameter int unsigned PC_W = 16
) (
  input  logic [N-1:0]      act,
  input  logic [N*PC_W-1:0] pcs,
  input  logic              win_v,
  input  logic [PC_W-1:0]   win_pc,
  output logic [N-1:0]      mask
);
  for (genvar j = 0; j < N; j++) begin : g_cmp
    assign mask[j] = win_v && act[j] && (pcs[j*PC_W +: PC_W] == win_pc);
  end
endmodule

// File: rtl/tfp_stat_accum.sv
module tfp_stat_accum #(
  parameter int unsigned N = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           pick,
  input  logic [N-1:0]   mask,
  output tfp_pkg::stat_t pick_cnt,
  output tfp_pkg::stat_t served_cnt
);
  tfp_pkg::stat_t served_inc;
  assign served_inc = tfp_pkg::stat_t'($countones(mask));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pick_cnt   <= '0;
      served_cnt <= '0;
    end else if (clr) begin
      pick_cnt   <= '0;
      served_cnt <= '0;
    end else begin
      pick_cnt   <= pick_cnt + tfp_pkg::stat_t'(pick);
      served_cnt <= served_cnt + served_inc;
    end
  end
endmodule

// File: rtl/thread_fetch_picker.sv
module thread_fetch_picker #(
  parameter int unsigned N_THR = tfp_pkg::DEF_THREADS,
  parameter int unsigned SP_W  = tfp_pkg::DEF_SP_W,
  parameter int unsigned PC_W  = tfp_pkg::DEF_PC_W,
  localparam int unsigned IDX_W = $clog2(N_THR),
  localparam int unsigned KEY_W = SP_W + PC_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr_stats_i,
  input  logic [N_THR-1:0]       act_i,
  input  logic [N_THR*SP_W-1:0]  sp_i,
  input  logic [N_THR*PC_W-1:0]  pc_i,
  output logic                   pick_vld_o,
  output logic [IDX_W-1:0]       win_idx_o,
  output logic [PC_W-1:0]        win_pc_o,
  output logic [N_THR-1:0]       served_mask_o,
  output logic [63:0]            pick_cnt_o,
  output logic [63:0]            served_cnt_o
);
  logic [N_THR*KEY_W-1:0] keys;
  for (genvar j = 0; j < N_THR; j++) begin : g_key
    assign keys[j*KEY_W +: KEY_W] = {sp_i[j*SP_W +: SP_W], pc_i[j*PC_W +: PC_W]};
  end

  // named internal events
  logic             nxt_vld;
  logic [KEY_W-1:0] nxt_key;
  logic [IDX_W-1:0] nxt_idx_raw;
  logic [IDX_W-1:0] nxt_idx;
  logic [PC_W-1:0]  nxt_pc;
  logic [N_THR-1:0] nxt_mask;

  tfp_pick_tree #(.N(N_THR), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_tree (
    .act(act_i), .keys(keys),
    .win_v(nxt_vld), .win_key(nxt_key), .win_idx(nxt_idx_raw)
  );

  assign nxt_pc  = nxt_vld ? nxt_key[PC_W-1:0] : '0;
  assign nxt_idx = nxt_vld ? nxt_idx_raw : '0;

  tfp_serve_mask #(.N(N_THR), .PC_W(PC_W)) u_mask (
    .act(act_i), .pcs(pc_i), .win_v(nxt_vld), .win_pc(nxt_pc), .mask(nxt_mask)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pick_vld_o    <= 1'b0;
      win_idx_o     <= '0;
      win_pc_o      <= '0;
      served_mask_o <= '0;
    end else begin
      pick_vld_o    <= nxt_vld;
      win_idx_o     <= nxt_idx;
      win_pc_o      <= nxt_pc;
      served_mask_o <= nxt_mask;
    end
  end

  tfp_stat_accum #(.N(N_THR)) u_stat (
    .clk(clk), .rst_n(rst_n), .clr(clr_stats_i),
    .pick(nxt_vld), .mask(nxt_mask),
    .pick_cnt(pick_cnt_o), .served_cnt(served_cnt_o)
  );
endmodule

// File: rtl/tfp_checker.sv
module tfp_checker #(
  parameter int unsigned N_THR = 16,
  parameter int unsigned PC_W  = 16,
  parameter int unsigned IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_stats_i,
  input logic [N_THR-1:0] act_i,
  input logic             pick_vld_o,
  input logic [IDX_W-1:0] win_idx_o,
  input logic [PC_W-1:0]  win_pc_o,
  input logic [N_THR-1:0] served_mask_o,
  input logic [63:0]      pick_cnt_o,
  input logic [63:0]      served_cnt_o
);
  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pick_vld_o |-> (served_mask_o == '0 && win_pc_o == '0 && win_idx_o == '0));

  // R5
  winner_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pick_vld_o |-> served_mask_o[win_idx_o]);

  // R6
  inactive_unserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((served_mask_o & ~$past(act_i)) == '0));

  // R8
  valid_follows_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pick_vld_o == ($past(act_i) != '0)));

  // R9
  pick_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_stats_i |=> (pick_cnt_o == $past(pick_cnt_o) + 64'(pick_vld_o)));

  // R9
  served_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_stats_i |=> (served_cnt_o == $past(served_cnt_o) + 64'($countones(served_mask_o))));

  // R10
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stats_i |=> (pick_cnt_o == '0 && served_cnt_o == '0));
endmodule

bind thread_fetch_picker tfp_checker #(.N_THR(N_THR), .PC_W(PC_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_stats_i(clr_stats_i), .act_i(act_i),
  .pick_vld_o(pick_vld_o), .win_idx_o(win_idx_o), .win_pc_o(win_pc_o),
  .served_mask_o(served_mask_o), .pick_cnt_o(pick_cnt_o), .served_cnt_o(served_cnt_o)
);

// File: tb/sim_thread_fetch_picker.sv
module sim_thread_fetch_picker;
  localparam int N = 16;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic [N-1:0] act = '0;
  logic [N*W-1:0] sp_f = '0;
  logic [N*W-1:0] pc_f = '0;
  logic vld;
  logic [3:0] idx;
  logic [W-1:0] wpc;
  logic [N-1:0] mask;
  logic [63:0] pcnt, scnt;

  always #4 clk = ~clk;

  thread_fetch_picker u0 (
    .clk(clk), .rst_n(rst_n), .clr_stats_i(clr), .act_i(act), .sp_i(sp_f), .pc_i(pc_f),
    .pick_vld_o(vld), .win_idx_o(idx), .win_pc_o(wpc), .served_mask_o(mask),
    .pick_cnt_o(pcnt), .served_cnt_o(scnt)
  );

  int n_chk = 0;
  int n_bad = 0;
  int a_sp[N];
  int a_pc[N];
  longint e_pcnt = 0;
  longint e_scnt = 0;

  task automatic chk(input string req, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic set_t(input int j, input bit a, input int sp, input int pc);
    act[j] = a; a_sp[j] = sp; a_pc[j] = pc;
    sp_f[j*W +: W] = W'(sp); pc_f[j*W +: W] = W'(pc);
  endtask

  task automatic all_off();
    for (int j = 0; j < N; j++) set_t(j, 1'b0, 16'hFFFF, 0);
  endtask

  // reference: strict-less scan keeps the lowest index on a full tie
  task automatic step(input string req);
    int best;
    longint ev, ei, ep, em, ecount;
    best = -1;
    for (int j = 0; j < N; j++)
      if (act[j] && (best < 0 || a_sp[j] < a_sp[best] ||
                     (a_sp[j] == a_sp[best] && a_pc[j] < a_pc[best])))
        best = j;
    ev = (best >= 0); ei = (best >= 0) ? best : 0; ep = (best >= 0) ? a_pc[best] : 0;
    em = 0; ecount = 0;
    if (best >= 0)
      for (int j = 0; j < N; j++)
        if (act[j] && a_pc[j] == a_pc[best]) begin em |= (64'd1 << j); ecount++; end
    if (clr) begin e_pcnt = 0; e_scnt = 0; end
    else begin e_pcnt += ev; e_scnt += ecount; end
    @(posedge clk);
    @(negedge clk);
    chk({req, " R8 valid"}, longint'(vld), ev);
    chk({req, " R1 idx"}, longint'(idx), ei);
    chk({req, " R1 pc"}, longint'(wpc), ep);
    chk({req, " R5 mask"}, longint'(mask), em);
    chk({req, " R9 picks"}, longint'(pcnt), e_pcnt);
    chk({req, " R9 served"}, longint'(scnt), e_scnt);
  endtask

  initial begin
    #1600000;
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    all_off();
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 vld", longint'(vld), 0);
    chk("R11 mask", longint'(mask), 0);
    chk("R11 picks", longint'(pcnt), 0);
    chk("R11 served", longint'(scnt), 0);
    rst_n = 1'b1;

    step("R7 idle");
    set_t(5, 1, 16'h0200, 16'h0100);
    step("R1 single");
    // R2: lower sp wins despite higher pc
    set_t(2, 1, 16'h0300, 16'h0010);
    set_t(9, 1, 16'h01F0, 16'h0800);
    step("R2 nesting");
    // R3: sp tie, smaller pc wins
    all_off();
    set_t(3, 1, 16'h0100, 16'h0500);
    set_t(7, 1, 16'h0100, 16'h0400);
    step("R3 pc tiebreak");
    // R4: full tie, lower index wins, both served
    all_off();
    set_t(11, 1, 16'h0100, 16'h0400);
    set_t(6, 1, 16'h0100, 16'h0400);
    set_t(14, 1, 16'h0100, 16'h0400);
    step("R4 index tiebreak");
    // R6: inactive thread with smallest key and matching pc ignored
    set_t(0, 0, 16'h0001, 16'h0400);
    set_t(1, 0, 16'h0050, 16'h0400);
    step("R6 inactive");
    // R5: matching pc under a different sp is served
    set_t(12, 1, 16'h0900, 16'h0400);
    set_t(13, 1, 16'h0100, 16'h0404);
    step("R5 other sp");
    // all threads same key: full service
    for (int j = 0; j < N; j++) set_t(j, 1, 16'h0800, 16'h0020);
    step("R5 all served");
    // R10: clear during a valid cycle
    clr = 1'b1;
    step("R10 clear");
    clr = 1'b0;
    step("R10 after clear");
    all_off();
    step("R7 idle again");

    for (int c = 0; c < 1500; c++) begin
      for (int j = 0; j < N; j++)
        set_t(j, 1'($urandom_range(0, 3) != 0), 16'h0100 - 16 * $urandom_range(0, 2),
              16'h0040 + 4 * $urandom_range(0, 2));
      if ($urandom_range(0, 9) == 0) act = '0;
      clr = (c % 97 == 50);
      step("R1 mixed");
    end
    clr = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule